// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is one general-purpose I/O port of up to sixteen pins behind a 32-bit, word-addressed register interface. Software sets each pin's direction and output level, reads back the synchronized pin levels, and arms a per-pin interrupt detector that fires on a falling edge, a rising edge, both edges, a low level or a high level. Pending events are latched in a status vector, filtered by a mask, and combined into one interrupt request line.

Software acknowledges events by writing ones to a clear word. It changes the mask only through a set word and a clear word, so no read-modify-write of the mask is needed. A soft reset word holds every port register at its reset value for as long as it reads one.

The register port is a plain single-cycle strobe. No data stream passes through the block, so it carries no valid/ready handshake and never applies back-pressure. A write takes effect at the clock edge where `bus_en` and `bus_we` are high. A read returns its data on `bus_rdata` one cycle after the strobe.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are zero and `irq` is low. Every pin therefore starts as an unmasked, disabled input with mode code 0.
- R2: Word 8 is the direction word (1 = output) and drives `pin_oe`. Word 6 is the output word and drives `pin_out`. Both read back as written.
- R3: Word 7 returns the pin levels after a two-flop synchronizer. A pin change reaches the read path after two clock edges.
- R4: Each pin has a 3-bit mode code: 0 falling, 1 rising, 2 low level, 3 high level, 4 both edges. Pins 0–7 use word 9 and pins 8–15 use word 10. Pin n sits at bits [4k+2:4k] with k = n mod 8, and bit 4k+3 reads zero.
- R5: In an edge mode, a matching transition of an enabled pin sets that pin's status bit (word 1) once. Holding the level afterwards does not set it again, and a transition of the opposite sense does not set it.
- R6: In a level mode, status re-sets on every cycle the level holds, even immediately after a clear. Mode codes 5, 6 and 7 never set status.
- R7: Word 0 is the per-pin enable. A pin whose enable bit is zero never sets its status bit.
- R8: Writing word 3 clears the status bits written as one and leaves the bits written as zero. A detection in the same cycle wins over the clear.
- R9: A one written to word 4 masks a pin and a one written to word 5 unmasks it. Zero bits leave the mask unchanged. Words 4 and 5 both read the mask. Word 2 reads status AND NOT mask, and `irq` is the OR of word 2.
- R10: Writing 1 to bit 0 of word 12 holds all port registers at zero and ignores writes to them until 0 is written there. Word 12 reads back this bit.
- R11: Bits at or above NPINS read zero and ignore writes. So do the mode fields of absent pins, word 11 and words 13–15.
- R12: A pin transition becomes visible on `irq` after the third rising clock edge (two synchronizer edges and one status edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output levels |
| pin_oe | output | NPINS | Output enables (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that a status bit never rises on a disabled pin, that the mask moves only on a set or clear write, that a clear without a coincident detection leaves the written bits low, and that an active soft reset keeps every register at zero. Only the bench scenarios can show the decoding of each mode code: one-shot edges against repeating levels, the inert codes 5–7, the nibble placement across the two mode words, the exact three-edge latency to `irq`, and the truncation of bits above the pin count.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    TRIG_FALL = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_HIGH = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] WA_ENABLE = 4'd0;
  localparam logic [ADDR_W-1:0] WA_STATUS = 4'd1;
  localparam logic [ADDR_W-1:0] WA_SHOW   = 4'd2;
  localparam logic [ADDR_W-1:0] WA_ACK    = 4'd3;
  localparam logic [ADDR_W-1:0] WA_MSET   = 4'd4;
  localparam logic [ADDR_W-1:0] WA_MCLR   = 4'd5;
  localparam logic [ADDR_W-1:0] WA_DRIVE  = 4'd6;
  localparam logic [ADDR_W-1:0] WA_LEVEL  = 4'd7;
  localparam logic [ADDR_W-1:0] WA_DIR    = 4'd8;
  localparam logic [ADDR_W-1:0] WA_MODE_LO = 4'd9;
  localparam logic [ADDR_W-1:0] WA_MODE_HI = 4'd10;
  localparam logic [ADDR_W-1:0] WA_SRST   = 4'd12;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
      q_prev <= '0;
    end else if (hold) begin
      meta_q <= '0;
      q      <= '0;
      q_prev <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
(
  input  logic       cur,
  input  logic       prev,
  input  logic [2:0] mode,
  output logic       hit
);
  always_comb begin
    case (mode)
      TRIG_FALL: hit = prev & ~cur;
      TRIG_RISE: hit = ~prev & cur;
      TRIG_LOW:  hit = ~cur;
      TRIG_HIGH: hit = cur;
      TRIG_BOTH: hit = prev ^ cur;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_regfile.sv
module gpio_irq_regfile
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]   pin_lvl,
  input  logic [NPINS-1:0]   hit,
  output logic [3*NPINS-1:0] mode_flat,
  output logic [NPINS-1:0]   drive_q,
  output logic [NPINS-1:0]   dir_q,
  output logic [NPINS-1:0]   show,
  output logic               srst_q
);
  localparam int PAD = DATA_W - NPINS;
  localparam int NIB = 8;

  logic [NPINS-1:0] en_q, st_q, mk_q;
  logic [2:0]       mode_q [NPINS];
  logic             wr, rd;
  logic [NPINS-1:0] wbits, ack_vec, set_vec;
  logic [DATA_W-1:0] mode_lo_w, mode_hi_w, rdata_d;
  logic             unused_ok;

  assign wr      = bus_en & bus_we;
  assign rd      = bus_en & ~bus_we;
  assign wbits   = bus_wdata[NPINS-1:0];
  assign ack_vec = (wr && bus_addr == WA_ACK) ? wbits : '0;
  assign set_vec = hit & en_q;
  assign show    = st_q & ~mk_q;
  assign unused_ok = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= 1'b0;
    else if (wr && bus_addr == WA_SRST) srst_q <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; st_q <= '0; mk_q <= '0; drive_q <= '0; dir_q <= '0;
      for (int i = 0; i < NPINS; i++) mode_q[i] <= '0;
    end else if (srst_q) begin
      en_q <= '0; st_q <= '0; mk_q <= '0; drive_q <= '0; dir_q <= '0;
      for (int i = 0; i < NPINS; i++) mode_q[i] <= '0;
    end else begin
      if (wr && bus_addr == WA_ENABLE) en_q    <= wbits;
      if (wr && bus_addr == WA_DRIVE)  drive_q <= wbits;
      if (wr && bus_addr == WA_DIR)    dir_q   <= wbits;
      if (wr && bus_addr == WA_MSET)   mk_q    <= mk_q | wbits;
      if (wr && bus_addr == WA_MCLR)   mk_q    <= mk_q & ~wbits;
      st_q <= (st_q & ~ack_vec) | set_vec;
      for (int i = 0; i < NPINS; i++) begin
        if (i < NIB) begin
          if (wr && bus_addr == WA_MODE_LO) mode_q[i] <= bus_wdata[4*(i%NIB) +: 3];
        end else begin
          if (wr && bus_addr == WA_MODE_HI) mode_q[i] <= bus_wdata[4*(i%NIB) +: 3];
        end
      end
    end
  end

  always_comb begin
    mode_lo_w = '0;
    mode_hi_w = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (i < NIB) mode_lo_w[4*(i%NIB) +: 3] = mode_q[i];
      else         mode_hi_w[4*(i%NIB) +: 3] = mode_q[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_flat
      assign mode_flat[3*g +: 3] = mode_q[g];
    end
  endgenerate

  always_comb begin
    case (bus_addr)
      WA_ENABLE:          rdata_d = {{PAD{1'b0}}, en_q};
      WA_STATUS:          rdata_d = {{PAD{1'b0}}, st_q};
      WA_SHOW:            rdata_d = {{PAD{1'b0}}, show};
      WA_MSET, WA_MCLR:   rdata_d = {{PAD{1'b0}}, mk_q};
      WA_DRIVE:           rdata_d = {{PAD{1'b0}}, drive_q};
      WA_LEVEL:           rdata_d = {{PAD{1'b0}}, pin_lvl};
      WA_DIR:             rdata_d = {{PAD{1'b0}}, dir_q};
      WA_MODE_LO:         rdata_d = mode_lo_w;
      WA_MODE_HI:         rdata_d = mode_hi_w;
      WA_SRST:            rdata_d = {{(DATA_W-1){1'b0}}, srst_q};
      default:            rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd) bus_rdata <= rdata_d;
  end

  // R7: a status bit may only rise on a pin that was enabled
  assert_status_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & ~$past(st_q) & ~$past(en_q)) == '0));

  // R10: an active soft reset keeps every register at zero
  assert_srst_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (en_q == '0 && st_q == '0 && mk_q == '0 && dir_q == '0 && drive_q == '0));

  // R9: the mask changes only through the set and clear words
  assert_mask_only_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr && (bus_addr == WA_MSET || bus_addr == WA_MCLR)) && !srst_q) |=> $stable(mk_q));

  // R8: acknowledged bits drop unless a detection coincides
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == WA_ACK && !srst_q) |=> ((st_q & $past(wbits) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0]   lvl, lvl_prev, hit, show;
  logic [3*NPINS-1:0] mode_flat;
  logic               srst;

  gpio_pin_sync #(.WIDTH(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .hold(srst),
    .d(pin_in), .q(lvl), .q_prev(lvl_prev)
  );

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_det
      gpio_trig_detect u_det (
        .cur(lvl[g]), .prev(lvl_prev[g]),
        .mode(mode_flat[3*g +: 3]), .hit(hit[g])
      );
    end
  endgenerate

  gpio_irq_regfile #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_lvl(lvl), .hit(hit), .mode_flat(mode_flat),
    .drive_q(pin_out), .dir_q(pin_oe), .show(show), .srst_q(srst)
  );

  assign irq = |show;
endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 12;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pins = '0, pin_out, pin_oe;
  logic irq;
  int nchk = 0, nfail = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port #(.NPINS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0; d = bus_rdata;
  endtask

  task automatic settle(); repeat (5) @(negedge clk); endtask

  task automatic t_reset();
    rd(0, rv); chk("R1 enable", rv, 0);
    rd(1, rv); chk("R1 status", rv, 0);
    rd(4, rv); chk("R1 mask", rv, 0);
    rd(9, rv); chk("R1 mode0", rv, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_drive();
    wr(8, 32'h0F0); wr(6, 32'hABC);
    chk("R2 pin_oe", pin_oe, 12'h0F0);
    chk("R2 pin_out", pin_out, 12'hABC);
    rd(6, rv); chk("R2 out readback", rv, 32'hABC);
    wr(8, 32'hFFFF_FFFF); rd(8, rv); chk("R11 dir upper bits", rv, 32'hFFF);
  endtask

  task automatic t_input();
    pins = 12'h5A5; settle();
    rd(7, rv); chk("R3 input level", rv, 32'h5A5);
    pins = 12'h000; settle();
    rd(7, rv); chk("R3 input low", rv, 32'h000);
  endtask

  task automatic t_rise_latency();
    wr(9, 32'h0000_1401); wr(0, 32'h007);
    @(negedge clk); pins[0] = 1;
    @(posedge clk); @(posedge clk); #1 chk("R12 irq before third edge", irq, 0);
    @(posedge clk); #1 chk("R12 irq after third edge", irq, 1);
    rd(1, rv); chk("R5 rising sets status", rv, 32'h1);
    wr(3, 32'h0); rd(1, rv); chk("R8 zero ack keeps status", rv, 32'h1);
    wr(3, 32'h1); settle(); rd(1, rv); chk("R5 held level no re-set", rv, 32'h0);
  endtask

  task automatic t_mask();
    pins[0] = 0; settle();
    wr(4, 32'h1); pins[0] = 1; settle();
    rd(1, rv); chk("R9 masked status latched", rv, 32'h1);
    rd(2, rv); chk("R9 display masked", rv, 32'h0);
    chk("R9 irq masked", irq, 0);
    rd(5, rv); chk("R9 mask readback", rv, 32'h1);
    wr(5, 32'h0); chk("R9 zero unmask no effect", irq, 0);
    wr(5, 32'h1); chk("R9 irq after unmask", irq, 1);
    rd(2, rv); chk("R9 display after unmask", rv, 32'h1);
    wr(3, 32'hFFF); chk("R8 ack drops irq", irq, 0);
  endtask

  task automatic t_fall_both();
    pins[1] = 1; settle(); rd(1, rv); chk("R5 falling ignores rise", rv, 0);
    pins[1] = 0; settle(); rd(1, rv); chk("R5 falling sets", rv, 32'h2);
    wr(3, 32'h2);
    pins[2] = 1; settle(); rd(1, rv); chk("R5 both on rise", rv, 32'h4);
    wr(3, 32'h4);
    pins[2] = 0; settle(); rd(1, rv); chk("R5 both on fall", rv, 32'h4);
    wr(3, 32'h4);
    pins[3] = 1; settle(); rd(1, rv); chk("R7 disabled pin silent", rv, 0);
  endtask

  task automatic t_level();
    wr(10, 32'h530); rd(10, rv); chk("R4 mode1 readback", rv, 32'h530);
    wr(0, 32'h607);
    pins[9] = 1; settle(); rd(1, rv); chk("R6 high level sets", rv, 32'h200);
    wr(3, 32'h200); rd(1, rv); chk("R6 level re-sets after ack", rv, 32'h200);
    pins[9] = 0; settle(); wr(3, 32'h200); rd(1, rv); chk("R6 ack after release", rv, 0);
    pins[10] = 1; settle(); pins[10] = 0; settle();
    rd(1, rv); chk("R6 code 5 inert", rv, 0);
  endtask

  task automatic t_width();
    wr(9, 32'hFFFF_FFFF); rd(9, rv); chk("R4 mode0 nibble bit3 zero", rv, 32'h7777_7777);
    wr(10, 32'hFFFF_FFFF); rd(10, rv); chk("R11 mode1 absent pins", rv, 32'h0000_7777);
    wr(0, 32'hFFFF_FFFF); rd(0, rv); chk("R11 enable upper bits", rv, 32'hFFF);
    rd(11, rv); chk("R11 reserved word", rv, 0);
  endtask

  task automatic t_srst();
    wr(12, 32'h1);
    rd(0, rv); chk("R10 enable held", rv, 0);
    chk("R10 pin_oe held", pin_oe, 0);
    wr(0, 32'h5); rd(0, rv); chk("R10 write ignored", rv, 0);
    rd(12, rv); chk("R10 srst readback", rv, 32'h1);
    wr(12, 32'h0); wr(0, 32'h5); rd(0, rv); chk("R10 released", rv, 32'h5);
    rd(9, rv); chk("R10 mode cleared", rv, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_drive();
    t_input();
    t_rise_latency();
    t_mask();
    t_fall_both();
    t_level();
    t_width();
    t_srst();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule